// File: doc/BRIEF.md
# Eight-Bit PWM Timer/Counter

An 8-bit timer/counter with one compare register and one waveform output. A two-bit mode field picks one of four behaviours. Normal mode is a free-running up counter. Clear-on-compare (CTC) mode wraps at the compare value. Fast PWM is a single-slope sawtooth. Phase-correct PWM is a dual-slope up/down triangle. A two-bit output mode field sets how the waveform pin reacts to compare matches and to the counter end points. The counter moves only on cycles where the count-enable tick is high, so an external prescaler sets the rate.

Software-side state is loaded through a synchronous write port. With `wr_sel_i`=0 the port writes the control register: `wr_data_i[1:0]` is the mode and `wr_data_i[3:2]` is the output mode. With `wr_sel_i`=1 the port writes the compare value. An overflow flag marks the end of each counting period. Writing one to `ovf_clr_i` clears the flag.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, the mode is normal (00), the output mode is 00, the compare value is 0, and the overflow flag, `wave_o` and `wave_oe_o` are all 0.
- R2: The count changes only on a cycle with `tick_i` high. In normal (00) and fast PWM (11) modes each tick adds one, and 0xFF wraps to 0x00.
- R3: In CTC mode (10), a tick taken while the count equals the compare value loads 0. Otherwise the count rises and wraps at 0xFF. In modes 00 and 10 a compare write takes effect on the next cycle.
- R4: In phase-correct mode (01) the count rises to 0xFF, turns there (0xFF→0xFE), falls to 0 and turns there (0x00→0x01).
- R5: In modes 01 and 11 a written compare value is held in a buffer. It is copied to the active compare value only on a tick taken at count 0xFF.
- R6: A tick at count 0xFF sets the overflow flag in modes 00, 10 and 11. In mode 01 the flag is set by a tick at count 0 while counting down.
- R7: A cycle with `ovf_clr_i` high clears the flag, unless a set event occurs in the same cycle, in which case the flag stays set.
- R8: In modes 00 and 10, a tick whose count equals the active compare value changes the output. Output mode 01 toggles it, 10 clears it and 11 sets it.
- R9: In fast PWM, output mode 10 sets the output on a tick at 0xFF (return to BOTTOM) and clears it on a match. Output mode 11 does the reverse. When both events fall on the same tick, the BOTTOM action wins.
- R10: In phase-correct mode, output mode 10 clears the output on a match while counting up and sets it on a match while counting down. Output mode 11 does the reverse.
- R11: In fast PWM with compare value 0xFF and output mode 10 or 11, the match is ignored. The output is then constant: 1 for mode 10 and 0 for mode 11.
- R12: `wave_oe_o` is high only when `dir_en_i` is high and the output mode is non-zero. Output mode 01 in the PWM modes (01, 11) is reserved and also leaves the pin undriven. `wave_o` reads 0 whenever `wave_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: control register, 1: compare value |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Count enable |
| dir_en_i | input | 1 | Pin direction enable |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| cnt_o | output | 8 | Current count |
| wave_o | output | 1 | Waveform output (0 when not driven) |
| wave_oe_o | output | 1 | Waveform output enable |
| ovf_o | output | 1 | Overflow flag |

## Verification
The reference model is run through every mode in turn. Some segments use a steady tick and others a tick every other cycle. A steady tick shows the wrap and turn-around points. A gapped tick shows that the count, the flag and the output hold between ticks. In CTC mode, compare writes made below and above the running count separate the early wrap from a full pass through 0xFF. In the PWM modes, writes made mid-period show whether the buffered value is applied at the period boundary rather than at once. The compare value 0xFF in fast PWM, the reserved output mode, and a clear held high across overflow ticks cover the conflict cases.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_CTC    = 2'b10,
    MODE_FAST   = 2'b11
  } mode_e;

  function automatic logic is_pwm(mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction
endpackage

// File: rtl/pwm_cnt_unit.sv
module pwm_cnt_unit
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  mode_e        mode_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = (mode_i == MODE_PHASE) ? up_q : 1'b1;
    if (tick_i) begin
      unique case (mode_i)
        MODE_PHASE: begin
          if (up_q) begin
            if (cnt_q == MAXV) begin up_d = 1'b0; cnt_d = cnt_q - ONE; end
            else cnt_d = cnt_q + ONE;
          end else begin
            if (cnt_q == '0) begin up_d = 1'b1; cnt_d = cnt_q + ONE; end
            else cnt_d = cnt_q - ONE;
          end
        end
        MODE_CTC: cnt_d = (cnt_q == cmp_i) ? '0 : cnt_q + ONE;
        default:  cnt_d = cnt_q + ONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  // R2
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R3
  ctc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_CTC && cnt_q == cmp_i) |=> cnt_q == '0);
  // R4
  phase_top_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_PHASE && up_q && cnt_q == MAXV) |=> (cnt_q == MAXV - ONE) && !up_q);
endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  mode_e        mode_i,
  input  logic         load_i,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] buf_q, act_q;
  logic         pwm;

  assign pwm = is_pwm(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= data_i;
      if (!pwm || load_i) act_q <= buf_q;
    end
  end

  // non-PWM modes see the written value at once
  assign cmp_o = pwm ? act_q : buf_q;

  // R5
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && !load_i) |=> $stable(act_q));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic [1:0]   com_i,
  input  logic         match_i,
  input  logic         bottom_i,
  input  logic         up_i,
  input  logic [W-1:0] cmp_i,
  input  logic         dir_en_i,
  output logic         wave_o,
  output logic         oe_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic wave_q, wave_d, hit;

  // compare value at TOP in fast PWM: match ignored
  assign hit = match_i && !(mode_i == MODE_FAST && com_i[1] && cmp_i == MAXV);

  always_comb begin
    wave_d = wave_q;
    unique case (mode_i)
      MODE_FAST: begin
        if (com_i[1]) begin
          if (bottom_i)  wave_d = ~com_i[0];
          else if (hit)  wave_d = com_i[0];
        end
      end
      MODE_PHASE: begin
        if (com_i[1] && hit) wave_d = up_i ? com_i[0] : ~com_i[0];
      end
      default: begin
        if (hit) begin
          unique case (com_i)
            2'b01:   wave_d = ~wave_q;
            2'b10:   wave_d = 1'b0;
            2'b11:   wave_d = 1'b1;
            default: wave_d = wave_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign oe_o   = dir_en_i && (com_i != 2'b00) && !(is_pwm(mode_i) && com_i == 2'b01);
  assign wave_o = oe_o && wave_q;

  // R12
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> dir_en_i);
  // R8
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !is_pwm(mode_i) && com_i == 2'b01) |=> wave_q != $past(wave_q));
  // R11
  top_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bottom_i && mode_i == MODE_FAST && com_i[1] && cmp_i == MAXV) |=> wave_q == !$past(com_i[0]));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         tick_i,
  input  logic         dir_en_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wave_o,
  output logic         wave_oe_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAXV = '1;

  mode_e        mode_q;
  logic [1:0]   com_q;
  logic         ovf_q, ovf_set;
  logic [W-1:0] cnt, cmp;
  logic         up, at_max, match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      com_q  <= 2'b00;
    end else if (wr_en_i && !wr_sel_i) begin
      mode_q <= mode_e'(wr_data_i[1:0]);
      com_q  <= wr_data_i[3:2];
    end
  end

  assign at_max = tick_i && (cnt == MAXV);
  assign match  = tick_i && (cnt == cmp);

  pwm_cnt_unit #(.W(W)) i_cnt (
    .clk_i, .rst_ni, .tick_i, .mode_i(mode_q), .cmp_i(cmp), .cnt_o(cnt), .up_o(up)
  );

  pwm_cmp_buf #(.W(W)) i_cmp (
    .clk_i, .rst_ni, .wr_i(wr_en_i && wr_sel_i), .data_i(wr_data_i),
    .mode_i(mode_q), .load_i(at_max), .cmp_o(cmp)
  );

  pwm_wave_gen #(.W(W)) i_wave (
    .clk_i, .rst_ni, .mode_i(mode_q), .com_i(com_q), .match_i(match),
    .bottom_i(at_max), .up_i(up), .cmp_i(cmp), .dir_en_i,
    .wave_o, .oe_o(wave_oe_o)
  );

  assign ovf_set = (mode_q == MODE_PHASE) ? (tick_i && cnt == '0 && !up) : at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set)   ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt;
  assign ovf_o = ovf_q;

  // R7
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !ovf_set) |=> !ovf_o);
  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set |=> ovf_o);
endmodule

// File: tb/test_pwm_timer8.sv
module test_pwm_timer8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, tick = 1'b0, dir_en = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt;
  logic       wave, wave_oe, ovf;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit gappy = 1'b0;
  int cyc = 0;
  string cnt_tag = "R2", wav_tag = "R8", ovf_tag = "R6";

  // reference state
  int m_cnt = 0, m_act = 0, m_buf = 0, m_mode = 0, m_com = 0;
  bit m_up = 1, m_wave = 0, m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer8 i_pwm_timer8 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tick_i(tick), .dir_en_i(dir_en), .ovf_clr_i(ovf_clr),
    .cnt_o(cnt), .wave_o(wave), .wave_oe_o(wave_oe), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_buf = 0; m_mode = 0; m_com = 0;
      m_up = 1; m_wave = 0; m_ovf = 0;
    end else begin
      bit pwm, top_tick, matched, set_ev;
      int eff;
      pwm      = (m_mode == 1) || (m_mode == 3);
      eff      = pwm ? m_act : m_buf;
      top_tick = tick && (m_cnt == 255);
      matched  = tick && (m_cnt == eff);
      set_ev   = (m_mode == 1) ? (tick && m_cnt == 0 && !m_up) : top_tick;
      if (set_ev) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (m_mode == 3) begin
        if (m_com >= 2) begin
          if (top_tick) m_wave = (m_com == 2);
          else if (matched && eff != 255) m_wave = (m_com == 3);
        end
      end else if (m_mode == 1) begin
        if (m_com >= 2 && matched) m_wave = (m_up == (m_com == 3));
      end else if (matched) begin
        if (m_com == 1) m_wave = !m_wave;
        else if (m_com == 2) m_wave = 0;
        else if (m_com == 3) m_wave = 1;
      end
      if (!pwm || top_tick) m_act = m_buf;
      if (tick) begin
        if (m_mode == 1) begin
          if (m_up) begin
            if (m_cnt == 255) begin m_up = 0; m_cnt = 254; end else m_cnt++;
          end else begin
            if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end else m_cnt--;
          end
        end else if (m_mode == 2 && m_cnt == eff) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % 256;
      end
      if (m_mode != 1) m_up = 1;
      if (wr_en && !wr_sel) begin m_mode = wr_data[1:0]; m_com = wr_data[3:2]; end
      if (wr_en && wr_sel) m_buf = wr_data;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    bit exp_oe;
    exp_oe = dir_en && (m_com != 0) && !(((m_mode == 1) || (m_mode == 3)) && m_com == 1);
    chk(cnt_tag, "cnt", cnt, m_cnt);
    chk(ovf_tag, "ovf", ovf, m_ovf);
    chk("R12", "oe", wave_oe, exp_oe);
    chk(wav_tag, "wave", wave, exp_oe ? m_wave : 0);
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      compare_all();
      tick = gappy ? cyc[0] : 1'b1;
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    run(1);
    wr_en = 1'b0;
  endtask

  // control word: [1:0] mode, [3:2] output mode
  function automatic logic [7:0] ctl(int mode, int com);
    return 8'((com << 2) | mode);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cnt", cnt, 0);
    chk("R1", "wave", wave, 0);
    chk("R1", "oe", wave_oe, 0);
    chk("R1", "ovf", ovf, 0);
    rst_n = 1'b1;
    run(2);

    // R2 normal counting, gapped then steady
    cnt_tag = "R2"; gappy = 1; run(300);
    gappy = 0; run(300);

    // R8 output on match in normal mode
    dir_en = 1; wav_tag = "R8";
    wr(1, 8'h10); wr(0, ctl(0, 1)); run(600);
    wr(0, ctl(0, 2)); run(300);
    wr(0, ctl(0, 3)); gappy = 1; run(400); gappy = 0;

    // R3 CTC: wrap at compare, immediate compare update
    cnt_tag = "R3";
    wr(1, 8'h20); wr(0, ctl(2, 1)); run(200);
    wr(1, 8'h05); run(400);
    wr(1, 8'hC0); run(400);

    // R12 pin not driven without direction enable
    wav_tag = "R12"; dir_en = 0; run(50); dir_en = 1;

    // R9 / R5 fast PWM, buffered compare
    cnt_tag = "R5"; wav_tag = "R9";
    wr(1, 8'h40); wr(0, ctl(3, 2)); run(300);
    wr(1, 8'h80); run(600);
    wr(0, ctl(3, 3)); gappy = 1; run(600); gappy = 0;

    // R12 reserved output mode in fast PWM
    wav_tag = "R12"; wr(0, ctl(3, 1)); run(100);

    // R11 compare at TOP in fast PWM
    wav_tag = "R11";
    wr(1, 8'hFF); wr(0, ctl(3, 2)); run(600);
    wr(0, ctl(3, 3)); run(300);

    // R4 / R10 phase-correct
    cnt_tag = "R4"; wav_tag = "R10";
    wr(1, 8'h30); wr(0, ctl(1, 2)); run(1100);
    wr(1, 8'h90); run(1100);
    wr(0, ctl(1, 3)); gappy = 1; run(1100); gappy = 0;
    wr(0, ctl(1, 1)); run(100);

    // R7 clear held across overflow ticks, then single pulses
    ovf_tag = "R7"; cnt_tag = "R2"; wav_tag = "R8";
    wr(0, ctl(0, 0));
    ovf_clr = 1; run(600); ovf_clr = 0;
    run(300);
    repeat (4) begin ovf_clr = 1; run(1); ovf_clr = 0; run(130); end

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule